// File: doc/BRIEF.md
# Event Counter Bank with Memory-Mapped Registers

The block holds eight 64-bit event counters that software programs and reads over a simple register port. Each counter is told by an 8-bit event code which line of a 256-wide event pulse vector it listens to. While its own enable bit and the bank-wide enable are both set, it adds one on every cycle that line is high. Software may load any counter at any time, either as one 64-bit access or as two 32-bit halves. A loaded counter keeps its value until it is enabled again.

When a counter rolls over from all ones to zero, it latches a status bit. A per-counter mask, set to all ones at reset, decides which latched bits reach the single interrupt output. Software clears status bits by writing ones to a clear location. A control word holds the per-counter enables, the bank enable, a two-bit channel filter field and a trace-tag enable bit. A read-only version word identifies the block.

Every access is a one-cycle request. A read returns its data, with a valid flag, one cycle after the request.

Top module: `perfbank_top`

## Requirements
- R1: After reset the control word reads 0 at 0x1C00, the mask reads 0xFF at 0x800, the status reads 0 at 0x808, the clear location 0x80C reads 0, and every counter and event select word reads 0. The version word at 0x1CF0 reads the VERSION parameter (default 0x21), and irq is 0.
- R2: Select word k at 0x1D00 + 4·k holds the codes of counters 4k to 4k+3, with counter c in bits 8·(c%4)+7 down to 8·(c%4). It reads back as written. Counter c counts pulses on evt_pulse[code of c].
- R3: A counter adds one at a clock edge only when its selected event bit is 1, its control bit c (bits 7:0) is 1 and the bank enable (control bit 26) is 1. If either enable is 0, the counter keeps its value.
- R4: A software write to a counter takes effect at the next edge even when the bank enable is 0, and the counter then holds that value while it is disabled. A write wins over an increment in the same cycle.
- R5: Counter c is at 0x1E00 + 8·c. A 64-bit access (bus_wide=1) reads or writes all 64 bits. A 32-bit access at +0 covers bits 31:0 and one at +4 covers bits 63:32, using bus_wdata[31:0] and returning the data in rsp_data[31:0] with the upper bits 0.
- R6: When counter c increments from all ones, it becomes 0 and status bit c becomes 1.
- R7: irq is 1 exactly when some status bit is 1 and its mask bit is 0. Mask bit c set to 1 hides counter c.
- R8: Writing 1 to bit c at 0x80C clears status bit c. Zero bits of that write leave status unchanged.
- R9: If a clear of status bit c and a new rollover of counter c fall in the same cycle, status bit c stays 1.
- R10: The control word stores only bits 7:0, 26, 28:27 and 29. The other bits read as 0 (writing 0xFFFFFFFF reads back 0x3C0000FF).
- R11: A read request sampled at an edge gives rsp_valid=1 and its data on rsp_data during the following cycle. The data are the register values from before any change made at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit counter access, 0 = 32-bit |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| evt_pulse | input | 256 | Event pulse vector, one bit per event code |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| irq | output | 1 | OR of unmasked status bits |

## Verification
A wrong lane in the select decode shows up as a counter that counts pulses on the wrong event line, or does not count at all. The counter readback shows it one cycle after the following read. A broken enable gate leaks increments into counters that were stopped or just loaded, and a value read right after a burst of pulses reveals it. A fault in the status logic shows at irq in the cycle after the rollover or clear edge: a set bit lost to a clear in the same cycle, a clear that misses, or a mask that fails to hide a bit.

// File: rtl/perfbank_pkg.sv
package perfbank_pkg;
    localparam int ADDR_W     = 16;
    localparam int REG_W      = 32;
    localparam int CODE_W     = 8;
    localparam int LANES      = REG_W / CODE_W;

    localparam logic [ADDR_W-1:0] OFS_MASK  = 16'h0800;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 16'h0808;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 16'h080C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 16'h1C00;
    localparam logic [ADDR_W-1:0] OFS_VER   = 16'h1CF0;
    localparam logic [ADDR_W-1:0] OFS_EVSEL = 16'h1D00;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 16'h1E00;

    localparam int CTRL_GLB_BIT  = 26;
    localparam int CTRL_CHAN_LO  = 27;
    localparam int CTRL_CHAN_W   = 2;
    localparam int CTRL_TAG_BIT  = 29;
endpackage

// File: rtl/perfbank_counter.sv
module perfbank_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic [1:0]   wr_mask_i,
    input  logic [W-1:0] wr_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam int HALF = W / 2;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_mask_i != 2'b00) begin
            if (wr_mask_i[0]) cnt_d[HALF-1:0] = wr_val_i[HALF-1:0];
            if (wr_mask_i[1]) cnt_d[W-1:HALF] = wr_val_i[W-1:HALF];
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i && (wr_mask_i == 2'b00) && (&cnt_q);

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && wr_mask_i == 2'b00) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && wr_mask_i == 2'b00) |=> $stable(cnt_q));
endmodule

// File: rtl/perfbank_evsel.sv
module perfbank_evsel #(
    parameter int N      = 8,
    parameter int CODE_W = 8
) (
    input  logic [N-1:0][CODE_W-1:0] codes_i,
    input  logic [(2**CODE_W)-1:0]   evt_i,
    output logic [N-1:0]             hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_sel
        assign hit_o[g] = evt_i[codes_i[g]];
    end
endmodule

// File: rtl/perfbank_regs.sv
module perfbank_regs
    import perfbank_pkg::*;
#(
    parameter int          N       = 8,
    parameter int          W       = 64,
    parameter logic [31:0] VERSION = 32'h0000_0021
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic                      bus_wide,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [W-1:0]              bus_wdata,
    input  logic [N-1:0][W-1:0]       cnt_i,
    input  logic [N-1:0]              wrap_i,
    output logic [N-1:0]              cnt_en_o,
    output logic [N-1:0][CODE_W-1:0]  codes_o,
    output logic [N-1:0][1:0]         cnt_wr_mask_o,
    output logic [W-1:0]              cnt_wr_val_o,
    output logic                      rsp_valid_o,
    output logic [W-1:0]              rsp_data_o,
    output logic                      irq_o
);
    localparam int HALF      = W / 2;
    localparam int NSEL      = (N + LANES - 1) / LANES;
    localparam int CNT_SPAN  = 8 * N;
    localparam int SEL_SPAN  = 4 * NSEL;
    localparam logic [REG_W-1:0] CTRL_KEEP =
        (REG_W'(1) << CTRL_TAG_BIT) |
        (REG_W'((1 << CTRL_CHAN_W) - 1) << CTRL_CHAN_LO) |
        (REG_W'(1) << CTRL_GLB_BIT) |
        REG_W'((1 << N) - 1);

    typedef struct packed {
        logic [REG_W-1:0]           ctrl;
        logic [N-1:0]               mask;
        logic [N-1:0]               status;
        logic [N-1:0][CODE_W-1:0]   codes;
        logic                       rsp_valid;
        logic [W-1:0]               rsp_data;
    } state_t;

    state_t st_d, st_q;

    logic          wr_req, rd_req;
    logic          cnt_hit, sel_hit, hi_half;
    int unsigned   cnt_idx, sel_idx;
    logic [N-1:0]  clr_bits;
    logic [W-1:0]  rd_val;

    always_comb begin
        wr_req  = bus_en && bus_we;
        rd_req  = bus_en && !bus_we;
        cnt_hit = (bus_addr >= OFS_CNT) && (32'(bus_addr) < 32'(OFS_CNT) + CNT_SPAN);
        sel_hit = (bus_addr >= OFS_EVSEL) && (32'(bus_addr) < 32'(OFS_EVSEL) + SEL_SPAN);
        cnt_idx = (32'(bus_addr) - 32'(OFS_CNT)) >> 3;
        sel_idx = (32'(bus_addr) - 32'(OFS_EVSEL)) >> 2;
        hi_half = bus_addr[2];
    end

    always_comb begin
        st_d          = st_q;
        st_d.rsp_valid = rd_req;
        clr_bits      = '0;
        cnt_wr_mask_o = '0;
        cnt_wr_val_o  = bus_wide ? bus_wdata : {bus_wdata[HALF-1:0], bus_wdata[HALF-1:0]};

        if (wr_req) begin
            if (bus_addr == OFS_MASK) begin
                st_d.mask = bus_wdata[N-1:0];
            end else if (bus_addr == OFS_CLR) begin
                clr_bits = bus_wdata[N-1:0];
            end else if (bus_addr == OFS_CTRL) begin
                st_d.ctrl = bus_wdata[REG_W-1:0] & CTRL_KEEP;
            end else if (sel_hit) begin
                for (int k = 0; k < N; k++) begin
                    if (k / LANES == sel_idx)
                        st_d.codes[k] = bus_wdata[(k % LANES) * CODE_W +: CODE_W];
                end
            end else if (cnt_hit) begin
                for (int k = 0; k < N; k++) begin
                    if (k == cnt_idx)
                        cnt_wr_mask_o[k] = bus_wide ? 2'b11 : (hi_half ? 2'b10 : 2'b01);
                end
            end
        end

        st_d.status = (st_q.status & ~clr_bits) | wrap_i;

        rd_val = '0;
        if (bus_addr == OFS_MASK) begin
            rd_val[N-1:0] = st_q.mask;
        end else if (bus_addr == OFS_STAT) begin
            rd_val[N-1:0] = st_q.status;
        end else if (bus_addr == OFS_CTRL) begin
            rd_val[REG_W-1:0] = st_q.ctrl;
        end else if (bus_addr == OFS_VER) begin
            rd_val[REG_W-1:0] = VERSION;
        end else if (sel_hit) begin
            for (int k = 0; k < N; k++) begin
                if (k / LANES == sel_idx)
                    rd_val[(k % LANES) * CODE_W +: CODE_W] = st_q.codes[k];
            end
        end else if (cnt_hit) begin
            for (int k = 0; k < N; k++) begin
                if (k == cnt_idx) begin
                    if (bus_wide)     rd_val = cnt_i[k];
                    else if (hi_half) rd_val[HALF-1:0] = cnt_i[k][W-1:HALF];
                    else              rd_val[HALF-1:0] = cnt_i[k][HALF-1:0];
                end
            end
        end
        if (rd_req) st_d.rsp_data = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_en_o    = st_q.ctrl[N-1:0] & {N{st_q.ctrl[CTRL_GLB_BIT]}};
    assign codes_o     = st_q.codes;
    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_data_o  = st_q.rsp_data;
    assign irq_o       = |(st_q.status & ~st_q.mask);

    // R9
    wrap_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i != '0) |=> ((st_q.status & $past(wrap_i)) == $past(wrap_i)));

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == OFS_CLR && wrap_i == '0)
        |=> ((st_q.status & $past(bus_wdata[N-1:0])) == '0));
endmodule

// File: rtl/perfbank_top.sv
module perfbank_top
    import perfbank_pkg::*;
#(
    parameter int          N       = 8,
    parameter int          W       = 64,
    parameter logic [31:0] VERSION = 32'h0000_0021
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic                    bus_wide,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [W-1:0]            bus_wdata,
    input  logic [(2**CODE_W)-1:0]  evt_pulse,
    output logic                    rsp_valid,
    output logic [W-1:0]            rsp_data,
    output logic                    irq
);
    logic [N-1:0][W-1:0]      cnt_vals;
    logic [N-1:0]             wraps, cnt_en, hits;
    logic [N-1:0][CODE_W-1:0] codes;
    logic [N-1:0][1:0]        wr_mask;
    logic [W-1:0]             wr_val;

    perfbank_regs #(.N(N), .W(W), .VERSION(VERSION)) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_wide      (bus_wide),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .cnt_i         (cnt_vals),
        .wrap_i        (wraps),
        .cnt_en_o      (cnt_en),
        .codes_o       (codes),
        .cnt_wr_mask_o (wr_mask),
        .cnt_wr_val_o  (wr_val),
        .rsp_valid_o   (rsp_valid),
        .rsp_data_o    (rsp_data),
        .irq_o         (irq)
    );

    perfbank_evsel #(.N(N), .CODE_W(CODE_W)) i_evsel (
        .codes_i (codes),
        .evt_i   (evt_pulse),
        .hit_o   (hits)
    );

    for (genvar g = 0; g < N; g++) begin : g_cnt
        perfbank_counter #(.W(W)) i_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (hits[g] && cnt_en[g]),
            .wr_mask_i (wr_mask[g]),
            .wr_val_i  (wr_val),
            .cnt_o     (cnt_vals[g]),
            .wrap_o    (wraps[g])
        );
    end

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we) |=> rsp_valid);
endmodule

// File: tb/test_perfbank_top.sv
module test_perfbank_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic [255:0] evt_pulse = '0;
    logic         rsp_valid;
    logic [63:0]  rsp_data;
    logic         irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    perfbank_top i_perfbank_top (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .evt_pulse(evt_pulse), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
    );

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected response act=%h exp=none", rsp_data);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_data !== e) begin
                    failures++;
                    $display("FAIL %s act=%h exp=%h", t, rsp_data, e);
                end
            end
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic wide, input logic [63:0] d);
        bus_en = 1; bus_we = 1; bus_wide = wide; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0; bus_wide = 0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic wide, input logic [63:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_en = 1; bus_we = 0; bus_wide = wide; bus_addr = a;
        @(negedge clk);
        bus_en = 0; bus_wide = 0;
    endtask

    task automatic pulse(input int idx, input int n);
        evt_pulse[idx] = 1'b1;
        repeat (n) @(negedge clk);
        evt_pulse[idx] = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq act=%b exp=%b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        bus_rd(16'h1C00, 0, 64'h0, "R1 ctrl reset");
        bus_rd(16'h0800, 0, 64'hFF, "R1 mask reset");
        bus_rd(16'h0808, 0, 64'h0, "R1 status reset");
        bus_rd(16'h080C, 0, 64'h0, "R1 clear reads zero");
        bus_rd(16'h1CF0, 0, 64'h21, "R1 version");
        bus_rd(16'h1E00, 1, 64'h0, "R1 counter0 reset");
        bus_rd(16'h1D04, 0, 64'h0, "R1 evsel1 reset");
        chk_irq(1'b0, "R1 irq reset");

        // R2 event code packing
        bus_wr(16'h1D00, 0, 64'h0302_0100);
        bus_wr(16'h1D04, 0, 64'hFFC8_1005);
        bus_rd(16'h1D00, 0, 64'h0302_0100, "R2 evsel0 readback");
        bus_rd(16'h1D04, 0, 64'hFFC8_1005, "R2 evsel1 readback");

        // R4 write with bank disabled, then hold
        bus_wr(16'h1E00, 1, 64'h1234_5678_9ABC_DEF0);
        bus_rd(16'h1E00, 1, 64'h1234_5678_9ABC_DEF0, "R4 write while disabled");
        pulse(0, 4);
        bus_rd(16'h1E00, 1, 64'h1234_5678_9ABC_DEF0, "R4 hold while disabled");

        // R3 counting with both enables; disabled neighbour stays
        bus_wr(16'h1C00, 0, 64'h0400_0001);
        pulse(0, 5);
        pulse(1, 3);
        bus_rd(16'h1E00, 1, 64'h1234_5678_9ABC_DEF5, "R3 counter0 counts");
        bus_rd(16'h1E08, 1, 64'h0, "R3 counter1 disabled");
        bus_wr(16'h1C00, 0, 64'h0000_0001);
        pulse(0, 3);
        bus_rd(16'h1E00, 1, 64'h1234_5678_9ABC_DEF5, "R3 bank enable off");

        // R2 mid-lane code selects its line only
        bus_wr(16'h1C00, 0, 64'h0400_0020);
        pulse(8'h10, 3);
        pulse(8'h11, 2);
        bus_rd(16'h1E28, 1, 64'h3, "R2 counter5 on code 0x10");

        // R6 R7 rollover and mask
        bus_wr(16'h1E38, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_wr(16'h1C00, 0, 64'h0400_0080);
        pulse(255, 1);
        bus_rd(16'h1E38, 1, 64'h0, "R6 counter7 wraps");
        bus_rd(16'h0808, 0, 64'h80, "R6 status set");
        chk_irq(1'b0, "R7 masked");
        bus_wr(16'h0800, 0, 64'h7F);
        chk_irq(1'b1, "R7 unmasked");

        // R8 clear
        bus_wr(16'h080C, 0, 64'h7F);
        bus_rd(16'h0808, 0, 64'h80, "R8 zero bits keep status");
        bus_wr(16'h080C, 0, 64'h80);
        bus_rd(16'h0808, 0, 64'h0, "R8 clear");
        chk_irq(1'b0, "R7 irq after clear");

        // R9 clear and rollover in same cycle
        bus_wr(16'h1E38, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        pulse(255, 1);
        bus_wr(16'h1E38, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        evt_pulse[255] = 1'b1;
        bus_wr(16'h080C, 0, 64'h80);
        evt_pulse[255] = 1'b0;
        bus_rd(16'h0808, 0, 64'h80, "R9 set wins over clear");
        chk_irq(1'b1, "R9 irq stays");
        bus_wr(16'h080C, 0, 64'h80);
        bus_rd(16'h0808, 0, 64'h0, "R9 later clear");

        // R5 32-bit halves
        bus_wr(16'h1E10, 0, 64'hAAAA_5555);
        bus_wr(16'h1E14, 0, 64'h0000_0001);
        bus_rd(16'h1E10, 1, 64'h0000_0001_AAAA_5555, "R5 wide read of halves");
        bus_rd(16'h1E14, 0, 64'h1, "R5 high half read");
        bus_rd(16'h1E10, 0, 64'hAAAA_5555, "R5 low half read");

        // R10 control field storage
        bus_wr(16'h1C00, 0, 64'hFFFF_FFFF);
        bus_rd(16'h1C00, 0, 64'h3C00_00FF, "R10 ctrl kept bits");
        bus_wr(16'h1C00, 0, 64'h0);
        bus_rd(16'h1C00, 0, 64'h0, "R10 ctrl cleared");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R11 missing responses act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end
endmodule